// File: doc/BRIEF.md
# Long-Descriptor Page Table Walker

This block turns a 32-bit virtual address into a 40-bit physical address. It reads a three-level table of 64-bit descriptors from memory. A walk starts at level 1, whose table base arrives as a low 32-bit word plus a high byte. At each level the block issues one descriptor read on a single-beat request/response memory port. It decodes the returned descriptor and then does one of two things: it descends to the next table, or it ends the walk with a result. The result is either a translation with its attribute bits or a fault. A fault carries a code and the level at which the walk stopped.

Level 1 holds four entries and is indexed by the two top address bits. Levels 2 and 3 hold 512 entries each. A walk can end at level 2 on a 2 MB section or at level 3 on a 4 KB page. Only one walk runs at a time. While `busy` is high, new requests are ignored. Each descriptor is checked in a fixed order: valid bit, then type, then the non-secure qualifiers, then write permission.

The control is a four-state machine:
- `ST_IDLE` is the idle state. It moves to `ST_ISSUE` when a request arrives.
- `ST_ISSUE` drives the read for one cycle and always moves to `ST_WAIT`.
- `ST_WAIT` holds until a response arrives. On a response it returns to `ST_ISSUE` if the descriptor is a table pointer, and otherwise moves to `ST_REPORT`.
- `ST_REPORT` presents the result for one cycle and always returns to `ST_IDLE`.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are low.
- R2: The level-1 descriptor address is {base[39:5], VA[31:30], 000}. Levels 2 and 3 use {table[39:12], idx, 000}. Here idx is VA[29:21] at level 2 and VA[20:12] at level 3, and table is the previous descriptor's bits [39:12] with 12 zero bits below.
- R3: A descriptor with bits [1:0] = 11 is a table pointer at levels 1 and 2 and a page at level 3. A page result is {desc[39:12], VA[11:0]}.
- R4: At level 2, bits [1:0] = 01 is a 2 MB section, and the result is {desc[39:21], VA[20:0]}.
- R5: A descriptor with bit 0 clear ends the walk with a translation fault, code 2, and produces no address.
- R6: Bits [1:0] = 01 at level 1 or at level 3 ends the walk with a format fault, code 1.
- R7: With `req_nonsecure` high, two descriptors give a secure-access fault, code 5: a table pointer with bit 63 clear, and a leaf with bit 5 clear. With `req_nonsecure` low, both bits are ignored.
- R8: A write to a leaf with bit 7 set gives a permission fault, code 4. A read of the same leaf succeeds. The secure-access check comes first.
- R9: On success, `res_attr` = {desc[54:53], desc[52], desc[11], desc[10], desc[9:8], desc[7:6], desc[5], desc[4:2]}. On a fault, `res_pa` and `res_attr` are zero and `fault_code` is non-zero. On success, `fault_code` is 0.
- R10: `busy` is high from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse. Exactly one read is issued per level visited. `req_valid` while busy starts no walk.
- R11: `stop_level` gives the level (1 to 3) at which the walk ended, for both faults and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_nonsecure | input | 1 | Access runs in non-secure mode |
| base_lo | input | 32 | Level-1 table base, low word |
| base_hi | input | 8 | Level-1 table base, high bits |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Descriptor read request, one cycle |
| mem_req_addr | output | 40 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor returned |
| done | output | 1 | Result valid, one cycle |
| res_fault | output | 1 | Walk ended in a fault |
| fault_code | output | 3 | 0 none, 1 format, 2 translation, 4 permission, 5 secure access |
| stop_level | output | 2 | Level at which the walk ended |
| res_pa | output | 40 | Physical address |
| res_attr | output | 13 | Attribute bits of the leaf |

## Verification
The sweep covers four level-1 entries, sixteen level-2 entries and sixteen level-3 entries. It runs every combination of read or write and secure or non-secure access, and varies the memory latency from one walk to the next. The level-2 and level-3 entries cycle through invalid, section, table, read-only, missing non-secure bit, table without bit 63, reserved type, and all-attributes patterns. This lets the checks separate four things: each fault code, the section and page address splices, the fault priority order, and how secure mode ignores bit 63 and bit 5. A second request raised during a walk shows that a busy walker ignores requests and keeps its result.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int DESC_W   = 64;
    localparam int ATTR_W   = 13;
    localparam int CODE_W   = 3;

    // descriptor bit positions the decoder relies on
    localparam int TBL_NS_BIT = 63;
    localparam int RO_BIT     = 7;
    localparam int LEAF_NS_BIT = 5;

    localparam logic [CODE_W-1:0] FC_NONE   = 3'd0;
    localparam logic [CODE_W-1:0] FC_FORMAT = 3'd1;
    localparam logic [CODE_W-1:0] FC_XLATE  = 3'd2;
    localparam logic [CODE_W-1:0] FC_PERM   = 3'd4;
    localparam logic [CODE_W-1:0] FC_SECURE = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REPORT = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        DK_TABLE = 2'd0,
        DK_LEAF  = 2'd1,
        DK_FAULT = 2'd2
    } desc_kind_e;

endpackage

// File: rtl/xlat_index.sv
// Forms the byte address of the descriptor for the current level.
module xlat_index #(
    parameter  int PA_W     = 40,
    parameter  int L1_IDX_W = 2,
    parameter  int IDX_W    = 9,
    parameter  int PAGE_W   = 12,
    localparam int VA_W     = L1_IDX_W + 2 * IDX_W + PAGE_W,
    localparam int HI_W     = VA_W - PAGE_W
) (
    input  logic [1:0]      level,
    input  logic [HI_W-1:0] va_hi,
    input  logic [PA_W-1:0] tbl_base,
    output logic [PA_W-1:0] desc_addr
);

    localparam int L1_LSB = L1_IDX_W + 3;

    logic [L1_IDX_W-1:0] idx1;
    logic [IDX_W-1:0]    idx2;
    logic [IDX_W-1:0]    idx3;

    assign idx1 = va_hi[HI_W-1 -: L1_IDX_W];
    assign idx2 = va_hi[2*IDX_W-1 -: IDX_W];
    assign idx3 = va_hi[IDX_W-1:0];

    always_comb begin
        unique case (level)
            2'd1:    desc_addr = {tbl_base[PA_W-1:L1_LSB], idx1, 3'b000};
            2'd2:    desc_addr = {tbl_base[PA_W-1:PAGE_W], idx2, 3'b000};
            default: desc_addr = {tbl_base[PA_W-1:PAGE_W], idx3, 3'b000};
        endcase
    end

    logic unused_base;
    assign unused_base = ^tbl_base[L1_LSB-1:0];

endmodule

// File: rtl/xlat_decode.sv
// Classifies one descriptor and forms the leaf result and checks.
module xlat_decode
    import xlat_pkg::*;
#(
    parameter  int PA_W   = 40,
    parameter  int IDX_W  = 9,
    parameter  int PAGE_W = 12,
    localparam int SECT_W = PAGE_W + IDX_W
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        level,
    input  logic              nonsec,
    input  logic              write,
    input  logic [SECT_W-1:0] va_lo,
    output desc_kind_e        kind,
    output logic [CODE_W-1:0] code,
    output logic [PA_W-1:0]   next_tbl,
    output logic [PA_W-1:0]   leaf_pa,
    output logic [ATTR_W-1:0] attr
);

    logic is_table;
    logic is_leaf;

    assign next_tbl = {desc[PA_W-1:PAGE_W], {PAGE_W{1'b0}}};

    always_comb begin
        is_table = (desc[1:0] == 2'b11) && (level != 2'd3);
        is_leaf  = ((level == 2'd2) && (desc[1:0] == 2'b01)) ||
                   ((level == 2'd3) && (desc[1:0] == 2'b11));
        kind     = DK_FAULT;
        code     = FC_FORMAT;
        leaf_pa  = '0;
        attr     = '0;
        if (!desc[0]) begin
            code = FC_XLATE;
        end else if (is_table) begin
            if (nonsec && !desc[TBL_NS_BIT]) begin
                code = FC_SECURE;
            end else begin
                kind = DK_TABLE;
                code = FC_NONE;
            end
        end else if (is_leaf) begin
            if (nonsec && !desc[LEAF_NS_BIT]) begin
                code = FC_SECURE;
            end else if (write && desc[RO_BIT]) begin
                code = FC_PERM;
            end else begin
                kind = DK_LEAF;
                code = FC_NONE;
                attr = {desc[54:53], desc[52], desc[11], desc[10],
                        desc[9:8], desc[7:6], desc[5], desc[4:2]};
                if (level == 2'd2)
                    leaf_pa = {desc[PA_W-1:SECT_W], va_lo};
                else
                    leaf_pa = {desc[PA_W-1:PAGE_W], va_lo[PAGE_W-1:0]};
            end
        end
    end

    logic unused_desc;
    assign unused_desc = ^{desc[62:55], desc[51:PA_W]};

endmodule

// File: rtl/xlat_walker.sv
// Three-level descriptor walker: one read per level, one walk at a time.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter  int PA_W     = 40,
    parameter  int L1_IDX_W = 2,
    parameter  int IDX_W    = 9,
    parameter  int PAGE_W   = 12,
    localparam int VA_W     = L1_IDX_W + 2 * IDX_W + PAGE_W,
    localparam int SECT_W   = PAGE_W + IDX_W,
    localparam int BHI_W    = PA_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_nonsecure,
    input  logic [31:0]       base_lo,
    input  logic [BHI_W-1:0]  base_hi,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              res_fault,
    output logic [CODE_W-1:0] fault_code,
    output logic [1:0]        stop_level,
    output logic [PA_W-1:0]   res_pa,
    output logic [ATTR_W-1:0] res_attr
);

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic              ns_q;
    logic [PA_W-1:0]   tbl_q;
    logic [1:0]        lvl_q;
    logic              fault_q;
    logic [CODE_W-1:0] code_q;
    logic [PA_W-1:0]   pa_q;
    logic [ATTR_W-1:0] attr_q;

    desc_kind_e        dec_kind;
    logic [CODE_W-1:0] dec_code;
    logic [PA_W-1:0]   dec_next;
    logic [PA_W-1:0]   dec_pa;
    logic [ATTR_W-1:0] dec_attr;
    logic [PA_W-1:0]   desc_addr;

    xlat_index #(
        .PA_W    (PA_W),
        .L1_IDX_W(L1_IDX_W),
        .IDX_W   (IDX_W),
        .PAGE_W  (PAGE_W)
    ) index_i (
        .level    (lvl_q),
        .va_hi    (va_q[VA_W-1:PAGE_W]),
        .tbl_base (tbl_q),
        .desc_addr(desc_addr)
    );

    xlat_decode #(
        .PA_W  (PA_W),
        .IDX_W (IDX_W),
        .PAGE_W(PAGE_W)
    ) decode_i (
        .desc    (mem_rsp_data),
        .level   (lvl_q),
        .nonsec  (ns_q),
        .write   (wr_q),
        .va_lo   (va_q[SECT_W-1:0]),
        .kind    (dec_kind),
        .code    (dec_code),
        .next_tbl(dec_next),
        .leaf_pa (dec_pa),
        .attr    (dec_attr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (mem_rsp_valid)
                           state_d = (dec_kind == DK_TABLE) ? ST_ISSUE : ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            ns_q    <= 1'b0;
            tbl_q   <= '0;
            lvl_q   <= 2'd1;
            fault_q <= 1'b0;
            code_q  <= FC_NONE;
            pa_q    <= '0;
            attr_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q  <= req_va;
            wr_q  <= req_write;
            ns_q  <= req_nonsecure;
            tbl_q <= {base_hi, base_lo};
            lvl_q <= 2'd1;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            if (dec_kind == DK_TABLE) begin
                tbl_q <= dec_next;
                lvl_q <= lvl_q + 2'd1;
            end else begin
                fault_q <= (dec_kind == DK_FAULT);
                code_q  <= dec_code;
                pa_q    <= dec_pa;
                attr_q  <= dec_attr;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        done          = (state_q == ST_REPORT);
        mem_req_addr  = desc_addr;
        res_fault     = fault_q;
        fault_code    = code_q;
        stop_level    = lvl_q;
        res_pa        = pa_q;
        res_attr      = attr_q;
    end

endmodule

// File: rtl/xlat_walker_chk.sv
// Temporal checks on the walker ports, bound to every instance.
module xlat_walker_chk #(
    parameter int PA_W = 40,
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_write,
    input logic            busy,
    input logic            mem_req_valid,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            done,
    input logic            res_fault,
    input logic [2:0]      fault_code,
    input logic [1:0]      stop_level,
    input logic [PA_W-1:0] res_pa,
    input logic [12:0]     res_attr
);

    logic [VA_W-1:0] va_c;
    logic            wr_c;
    logic            first_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_c    <= '0;
            wr_c    <= 1'b0;
            first_c <= 1'b0;
        end else if (req_valid && !busy) begin
            va_c    <= req_va;
            wr_c    <= req_write;
            first_c <= 1'b1;
        end else if (mem_req_valid) begin
            first_c <= 1'b0;
        end
    end

    a_r2_first_read_index: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && first_c |-> mem_req_addr[4:3] == va_c[VA_W-1 -: 2]
                                     && mem_req_addr[2:0] == 3'b000);

    a_r3_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_fault |-> res_pa[11:0] == va_c[11:0]);

    a_r4_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_fault && stop_level == 2'd2 |-> res_pa[20:0] == va_c[20:0]);

    a_r8_perm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_fault && fault_code == 3'd4 |-> wr_c);

    a_r9_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done && res_fault |-> res_pa == '0 && res_attr == '0 && fault_code != 3'd0);

    a_r9_ok_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_fault |-> fault_code == 3'd0);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid && busy);

    a_r10_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r11_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> stop_level != 2'd0);

endmodule

bind xlat_walker xlat_walker_chk #(.PA_W(PA_W), .VA_W(VA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_write    (req_write),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .done         (done),
    .res_fault    (res_fault),
    .fault_code   (fault_code),
    .stop_level   (stop_level),
    .res_pa       (res_pa),
    .res_attr     (res_attr)
);

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;

    localparam logic [39:0] BASE = 40'h12_3456_7820;
    localparam logic [39:0] L2A  = 40'h00_4000_1000;
    localparam logic [39:0] L2B  = 40'h00_4000_2000;
    localparam logic [63:0] B63  = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_nonsecure = 1'b0;
    logic        busy, mem_req_valid, done, res_fault;
    logic [39:0] mem_req_addr, res_pa;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic [2:0]  fault_code;
    logic [1:0]  stop_level;
    logic [12:0] res_attr;

    always #4 clk = ~clk;

    xlat_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_nonsecure(req_nonsecure),
        .base_lo(BASE[31:0]), .base_hi(BASE[39:32]), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .res_fault(res_fault), .fault_code(fault_code),
        .stop_level(stop_level), .res_pa(res_pa), .res_attr(res_attr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int lat = 1;
    int n_reads = 0;

    logic [63:0] mem [logic [39:0]];

    logic        e_fault;
    logic [2:0]  e_code;
    logic [1:0]  e_lvl;
    logic [39:0] e_pa;
    logic [12:0] e_attr;
    int          e_nrd;
    logic [39:0] exp_addr [0:2];

    function automatic logic [63:0] rd(input logic [39:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // expected walk computed from the requirements
    task automatic ref_walk(input logic [31:0] va, input logic wr, input logic ns);
        logic [39:0] tbl;
        logic [39:0] a;
        logic [63:0] d;
        int lvl;
        bit fin;
        tbl = BASE; lvl = 1; fin = 0; e_nrd = 0;
        e_fault = 0; e_code = 0; e_pa = '0; e_attr = '0; e_lvl = 2'd1;
        while (!fin) begin
            case (lvl)
                1:       a = {tbl[39:5], va[31:30], 3'b000};
                2:       a = {tbl[39:12], va[29:21], 3'b000};
                default: a = {tbl[39:12], va[20:12], 3'b000};
            endcase
            exp_addr[e_nrd] = a;
            e_nrd++;
            d = rd(a);
            e_lvl = 2'(lvl);
            fin = 1;
            if (!d[0]) begin
                e_fault = 1; e_code = 3'd2;
            end else if (d[1:0] == 2'b11 && lvl < 3) begin
                if (ns && !d[63]) begin
                    e_fault = 1; e_code = 3'd5;
                end else begin
                    tbl = {d[39:12], 12'h000}; lvl++; fin = 0;
                end
            end else if (lvl == 1 || (lvl == 3 && d[1:0] == 2'b01)) begin
                e_fault = 1; e_code = 3'd1;
            end else if (ns && !d[5]) begin
                e_fault = 1; e_code = 3'd5;
            end else if (wr && d[7]) begin
                e_fault = 1; e_code = 3'd4;
            end else begin
                e_pa = (lvl == 2) ? {d[39:21], va[20:0]} : {d[39:12], va[11:0]};
                e_attr = {d[54:53], d[52], d[11], d[10], d[9:8], d[7:6], d[5], d[4:2]};
            end
        end
    endtask

    function automatic string tag_of();
        if (e_fault) begin
            case (e_code)
                3'd1:    return "R6";
                3'd2:    return "R5";
                3'd4:    return "R8";
                default: return "R7";
            endcase
        end
        return (e_lvl == 2'd2) ? "R4" : "R3";
    endfunction

    // memory model: serves each read after lat cycles, checks its address (R2)
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            while (mem_req_valid) begin
                check(n_reads < e_nrd, "R10", "extra read", 64'(n_reads), 64'(e_nrd));
                if (n_reads < 3)
                    check(mem_req_addr == exp_addr[n_reads], "R2", "read address",
                          64'(mem_req_addr), 64'(exp_addr[n_reads]));
                n_reads++;
                repeat (lat) @(negedge clk);
                mem_rsp_data  = rd(mem_req_addr_hold);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    logic [39:0] mem_req_addr_hold;
    always @(posedge clk) if (mem_req_valid) mem_req_addr_hold <= mem_req_addr;

    task automatic wait_done(output bit seen);
        int w;
        w = 0;
        while (!done && w < 100) begin
            @(negedge clk);
            w++;
        end
        seen = done;
    endtask

    task automatic run_walk(input logic [31:0] va, input logic wr, input logic ns);
        bit seen;
        ref_walk(va, wr, ns);
        n_reads = 0;
        @(negedge clk);
        req_va = va; req_write = wr; req_nonsecure = ns; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        if (!seen) begin
            check(0, "R10", "walk never finished", 64'(0), 64'(1));
        end else begin
            check({res_fault, fault_code} == {e_fault, e_code}, tag_of(), "fault/code",
                  64'({res_fault, fault_code}), 64'({e_fault, e_code}));
            check(res_pa == e_pa, tag_of(), "physical address", 64'(res_pa), 64'(e_pa));
            check(res_attr == e_attr, "R9", "attributes", 64'(res_attr), 64'(e_attr));
            check(stop_level == e_lvl, "R11", "stop level", 64'(stop_level), 64'(e_lvl));
            check(n_reads == e_nrd, "R10", "read count", 64'(n_reads), 64'(e_nrd));
        end
        @(negedge clk);
    endtask

    function automatic logic [39:0] l3_base(input int i);
        return 40'h00_5000_0000 + 40'(i) * 40'h1000;
    endfunction

    task automatic build_tables();
        logic [63:0] sec;
        logic [63:0] frm;
        mem[BASE]      = B63 | 64'(L2A) | 64'h3;
        mem[BASE + 8]  = 64'h0000_0000_dead_0000;
        mem[BASE + 16] = B63 | 64'h0000_00c0_0000_0000 | 64'h21;
        mem[BASE + 24] = 64'(L2B) | 64'h3;
        mem[L2B]       = 64'h0000_0077_0020_0000 | 64'h421;
        for (int i = 0; i < 16; i++) begin
            sec = 64'h0000_0080_0000_0000 + (64'(i) << 21);
            case (i % 8)
                0: mem[L2A + 40'(i * 8)] = 64'(i) << 12;
                1: mem[L2A + 40'(i * 8)] = sec | 64'h661;
                2: mem[L2A + 40'(i * 8)] = B63 | 64'(l3_base(i)) | 64'h3;
                3: mem[L2A + 40'(i * 8)] = sec | 64'h4a1;
                4: mem[L2A + 40'(i * 8)] = sec | 64'h401;
                5: mem[L2A + 40'(i * 8)] = 64'(l3_base(i)) | 64'h3;
                6: mem[L2A + 40'(i * 8)] = B63 | 64'(l3_base(i)) | 64'h3;
                default: mem[L2A + 40'(i * 8)] = 64'h7f80_0000_0000_0000 |
                        64'h0060_0000_0000_0000 | 64'h0010_0000_0000_0000 |
                        sec | 64'hffd;
            endcase
            if (i % 8 == 2 || i % 8 == 5 || i % 8 == 6) begin
                for (int j = 0; j < 16; j++) begin
                    frm = 64'h0000_0030_0000_0000 + (64'(i * 16 + j) << 12);
                    case (j % 6)
                        0: mem[l3_base(i) + 40'(j * 8)] = frm;
                        1: mem[l3_base(i) + 40'(j * 8)] = frm | 64'h423;
                        2: mem[l3_base(i) + 40'(j * 8)] = frm | 64'h4a3;
                        3: mem[l3_base(i) + 40'(j * 8)] = frm | 64'h421;
                        4: mem[l3_base(i) + 40'(j * 8)] = frm | 64'h403;
                        default: mem[l3_base(i) + 40'(j * 8)] = frm |
                                64'h0060_0000_0000_0000 | 64'h0010_0000_0000_0000 |
                                64'hebf;
                    endcase
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", n_cmp, 0);
        finish_run();
    end

    initial begin
        int k;
        int idle_dones;
        bit seen;
        logic [31:0] va_a;
        e_nrd = 0;
        build_tables();
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req_valid, "R1", "outputs in reset",
              64'({busy, done, mem_req_valid}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req_valid, "R1", "outputs after reset",
              64'({busy, done, mem_req_valid}), 64'(0));

        // sweep of table patterns, access kind, security mode and latency
        k = 0;
        for (int l1 = 0; l1 < 4; l1++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < ((l1 == 0) ? 16 : 1); j++)
                    for (int wr = 0; wr < 2; wr++)
                        for (int ns = 0; ns < 2; ns++) begin
                            lat = 1 + (k % 3);
                            k++;
                            run_walk({2'(l1), 9'(i), 9'(j), 12'((i * 37 + j * 11 + wr * 5) & 12'hfff)},
                                     wr[0], ns[0]);
                        end

        // R10: a request raised during a walk is ignored
        va_a = {2'd0, 9'd2, 9'd1, 12'h123};
        ref_walk(va_a, 1'b0, 1'b1);
        n_reads = 0;
        lat = 2;
        @(negedge clk);
        req_va = va_a; req_write = 1'b0; req_nonsecure = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_va = {2'd1, 30'h0};
        check(busy, "R10", "busy during walk", 64'(busy), 64'(1));
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        check(seen && res_pa == e_pa && !res_fault, "R10", "first walk result kept",
              64'(res_pa), 64'(e_pa));
        @(negedge clk);
        check(!busy, "R10", "idle after walk", 64'(busy), 64'(0));
        idle_dones = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (done || busy) idle_dones++;
        end
        check(idle_dones == 0, "R10", "no second walk", 64'(idle_dones), 64'(0));

        finish_run();
    end

endmodule